// File: doc/BRIEF.md
# Acknowledge-Paced Printer Stream Gate

This block sits between a producer of printable characters and the transmit side of a slow serial printer link. Characters arrive on a valid/ready stream, are cleared to seven bits and are passed one at a time to a single-entry transmit register that is drained by a valid/ready handshake toward the serializer. The block counts the characters it forwards. Each time a fixed-size block completes, it issues an end-of-text byte on the same transmit handshake. It then refuses further input until the printer returns an acknowledge byte on the receive strobe.

The block counter is a free-running register of `CNT_W` bits. It is preset to `RELOAD` and advances once per forwarded character. The block is over when the counter wraps to zero, so a block holds `2**CNT_W - RELOAD` characters (254 with the defaults of 8 and 2). Receiving the acknowledge reloads the preset. A busy output tells the system that the gate is closed. With a 1200 baud link, the transmit handshake runs at roughly one byte per 8.3 ms. Nothing inside the block depends on that rate.

Top module: `etx_flow_ctrl`

## Requirements
- R1: After a synchronous reset, `tx_valid` is 0, `busy` is 0 and `in_ready` is 1.
- R2: Each accepted character appears once on `tx_data`, in arrival order, with bit 7 forced to 0 and bits 6..0 unchanged.
- R3: After exactly `2**CNT_W - RELOAD` characters have been accepted since reset or since the last acknowledge, the next byte offered on the transmit port is the marker 0x03. It follows the last character of the block directly.
- R4: From the cycle after the last character of a block is accepted until an acknowledge releases the gate, `busy` is 1 and `in_ready` is 0. Otherwise `busy` is 0, and `in_ready` is 1 whenever the transmit register is empty or being drained in that cycle.
- R5: While `tx_valid` is 1 and `tx_ready` is 0, `tx_valid` stays 1 and `tx_data` keeps its value on the next cycle. This applies to characters and to the marker.
- R6: An acknowledge is `rx_stb` high with `rx_data` equal to 0x06. It releases the gate only after the marker has been accepted by the transmit port. `busy` falls on the next cycle and the counter restarts at `RELOAD`, so the following block again holds the full count.
- R7: A received byte other than 0x06 while waiting, and any received byte while not waiting (including 0x06), has no effect: `busy` and the block length are unchanged.
- R8: Reset asserted in the middle of a block discards the pending byte and the partial count. The next block holds the full count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Upstream character valid |
| in_data | input | DATA_W | Upstream character |
| in_ready | output | 1 | Character accepted when high together with in_valid |
| rx_stb | input | 1 | One-cycle strobe for a byte received from the printer |
| rx_data | input | DATA_W | Received byte |
| tx_valid | output | 1 | Transmit byte valid |
| tx_data | output | DATA_W | Transmit byte (character or marker) |
| tx_ready | input | 1 | Serializer takes the byte when high together with tx_valid |
| busy | output | 1 | High while the gate is closed for the marker and acknowledge |

## Verification
The bench builds the block with `CNT_W = 4` and `RELOAD = 2`, so a block holds 14 characters. This allows hundreds of block boundaries, marker sends and acknowledge releases within a short run. Mid-block resets also come early enough to show that the next block holds the full count again. A reference model advances on every clock and predicts the transmit sequence, the gate state and the upstream ready. The stimulus uses throughput levels ranging from a free-flowing transmit port to heavy backpressure. Acknowledge and unrelated bytes are injected both while the gate waits and while it is open.

// File: rtl/etx_flow_pkg.sv
package etx_flow_pkg;

    typedef enum logic [1:0] {
        ST_PASS = 2'd0,
        ST_MARK = 2'd1,
        ST_SENT = 2'd2,
        ST_WAIT = 2'd3
    } gate_state_e;

endpackage

// File: rtl/etx_blk_counter.sv
module etx_blk_counter #(
    parameter int CNT_W  = 8,
    parameter int RELOAD = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic bump,
    input  logic reload,
    output logic last
);
    localparam logic [CNT_W-1:0] PRESET = CNT_W'(RELOAD);
    localparam logic [CNT_W-1:0] TOP    = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (reload) begin
            cnt_d = PRESET;
        end else if (bump) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= PRESET;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign last = bump && (cnt_q == TOP);

    AST_RELOAD_PRESET: assert property (@(posedge clk) disable iff (rst)
        reload |=> (cnt_q == PRESET)) else $error("AST_RELOAD_PRESET"); // R6

endmodule

// File: rtl/etx_ack_match.sv
module etx_ack_match #(
    parameter int                DATA_W = 8,
    parameter logic [DATA_W-1:0] ACK    = 8'h06
) (
    input  logic              stb,
    input  logic [DATA_W-1:0] data,
    input  logic              armed,
    output logic              hit
);
    always_comb begin
        hit = stb && armed && (data == ACK);
    end
endmodule

// File: rtl/etx_flow_ctrl.sv
module etx_flow_ctrl
    import etx_flow_pkg::*;
#(
    parameter int                DATA_W = 8,
    parameter int                CNT_W  = 8,
    parameter int                RELOAD = 2,
    parameter logic [DATA_W-1:0] MARK   = 8'h03,
    parameter logic [DATA_W-1:0] ACK    = 8'h06
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    input  logic              rx_stb,
    input  logic [DATA_W-1:0] rx_data,
    output logic              tx_valid,
    output logic [DATA_W-1:0] tx_data,
    input  logic              tx_ready,
    output logic              busy
);
    localparam logic [DATA_W-1:0] LOW_MASK = {1'b0, {(DATA_W-1){1'b1}}};

    typedef struct packed {
        gate_state_e       st;
        logic              tx_vld;
        logic [DATA_W-1:0] tx_byte;
    } gate_regs_t;

    gate_regs_t r_d, r_q;
    logic slot_free, take, blk_last, ack_hit, waiting;

    assign waiting = (r_q.st == ST_WAIT);

    etx_blk_counter #(.CNT_W(CNT_W), .RELOAD(RELOAD)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .bump   (take),
        .reload (ack_hit),
        .last   (blk_last)
    );

    etx_ack_match #(.DATA_W(DATA_W), .ACK(ACK)) u_ack (
        .stb   (rx_stb),
        .data  (rx_data),
        .armed (waiting),
        .hit   (ack_hit)
    );

    always_comb begin
        slot_free = !r_q.tx_vld || tx_ready;
        in_ready  = (r_q.st == ST_PASS) && slot_free;
        take      = in_valid && in_ready;

        r_d = r_q;
        if (r_q.tx_vld && tx_ready) begin
            r_d.tx_vld = 1'b0;
        end
        unique case (r_q.st)
            ST_PASS: begin
                if (take) begin
                    r_d.tx_vld  = 1'b1;
                    r_d.tx_byte = in_data & LOW_MASK;
                    if (blk_last) begin
                        r_d.st = ST_MARK;
                    end
                end
            end
            ST_MARK: begin
                if (slot_free) begin
                    r_d.tx_vld  = 1'b1;
                    r_d.tx_byte = MARK;
                    r_d.st      = ST_SENT;
                end
            end
            ST_SENT: begin
                if (tx_ready) begin
                    r_d.st = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (ack_hit) begin
                    r_d.st = ST_PASS;
                end
            end
            default: r_d.st = ST_PASS;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.st      <= ST_PASS;
            r_q.tx_vld  <= 1'b0;
            r_q.tx_byte <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign tx_valid = r_q.tx_vld;
    assign tx_data  = r_q.tx_byte;
    assign busy     = (r_q.st != ST_PASS);

    AST_SYNC_CLEAR: assert property (@(posedge clk)
        rst |=> (!busy && !tx_valid)) else $error("AST_SYNC_CLEAR"); // R8
    AST_TX_MSB_CLEAR: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> !tx_data[DATA_W-1]) else $error("AST_TX_MSB_CLEAR"); // R2
    AST_BLOCK_END: assert property (@(posedge clk) disable iff (rst)
        (take && blk_last) |=> (busy && tx_valid)) else $error("AST_BLOCK_END"); // R3
    AST_MARK_OUT: assert property (@(posedge clk) disable iff (rst)
        (r_q.st == ST_SENT) |-> (tx_valid && tx_data == MARK)) else $error("AST_MARK_OUT"); // R3
    AST_NO_INTAKE_BUSY: assert property (@(posedge clk) disable iff (rst)
        busy |-> !in_ready) else $error("AST_NO_INTAKE_BUSY"); // R4
    AST_TX_HOLD: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data))) else $error("AST_TX_HOLD"); // R5
    AST_ACK_OPEN: assert property (@(posedge clk) disable iff (rst)
        ack_hit |=> !busy) else $error("AST_ACK_OPEN"); // R6
    AST_NOISE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (waiting && !ack_hit) |=> busy) else $error("AST_NOISE_HOLD"); // R7

endmodule

// File: tb/etx_flow_ctrl_test.sv
module etx_flow_ctrl_test;
    localparam int CNT_W  = 4;
    localparam int RELOAD = 2;
    localparam int BLK    = (1 << CNT_W) - RELOAD;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_ready;
    logic       rx_stb = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic       tx_valid;
    logic [7:0] tx_data;
    logic       tx_ready = 1'b0;
    logic       busy;

    always #5 clk = ~clk;

    etx_flow_ctrl #(.DATA_W(8), .CNT_W(CNT_W), .RELOAD(RELOAD)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .rx_stb(rx_stb), .rx_data(rx_data),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready), .busy(busy)
    );

    int total = 0;
    int bad   = 0;

    // knobs
    logic       rst_k = 1'b1;
    int         p_in = 0;
    int         p_tx = 0;
    logic       rx_go = 1'b0;
    logic [7:0] rx_val = 8'h00;

    // reference model
    int         phase = 0;   // 0 open, 1 marker owed, 2 awaiting ack
    int         cnt = 0;
    logic [7:0] exp_q[$];
    logic       started = 1'b0;
    logic       last_take = 1'b0;
    logic       prev_hold = 1'b0;
    logic [7:0] prev_data = 8'h00;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step();
        logic acc, hs;
        int   ph0;
        logic [7:0] got;
        @(negedge clk);
        rst = rst_k;
        if (!(in_valid && !last_take) || rst_k) begin
            in_valid = (($urandom % 100) < p_in);
            in_data  = 8'($urandom);
        end
        tx_ready = (($urandom % 100) < p_tx);
        rx_stb   = rx_go;
        rx_data  = rx_val;
        rx_go    = 1'b0;
        #1;
        if (started) begin
            chk(busy == (phase != 0), "R4 busy", busy, phase != 0);
            chk(in_ready == ((phase == 0) && (!tx_valid || tx_ready)), "R4 in_ready",
                in_ready, (phase == 0) && (!tx_valid || tx_ready));
            chk(tx_valid == (exp_q.size() != 0), "R3 tx_valid", tx_valid, exp_q.size() != 0);
            if (prev_hold)
                chk(tx_valid && tx_data == prev_data, "R5 hold", tx_data, prev_data);
        end
        acc = in_valid && in_ready;
        hs  = tx_valid && tx_ready;
        ph0 = phase;
        if (rst) begin
            phase = 0; cnt = 0; exp_q.delete();
            last_take = 1'b0; prev_hold = 1'b0;
            started = 1'b1;
        end else if (started) begin
            if (hs && exp_q.size() != 0) begin
                got = exp_q.pop_front();
                if (ph0 == 1 && exp_q.size() == 0) begin
                    chk(tx_data == got, "R3 marker", tx_data, got);
                    phase = 2;
                end else begin
                    chk(tx_data == got, "R2 data", tx_data, got);
                end
            end
            if (acc) begin
                exp_q.push_back(in_data & 8'h7f);
                cnt++;
                if (cnt == BLK) begin
                    exp_q.push_back(8'h03);
                    phase = 1;
                    cnt = 0;
                end
            end
            if (ph0 == 2 && rx_stb && rx_data == 8'h06) phase = 0;
            last_take = acc;
            prev_hold = tx_valid && !tx_ready;
            prev_data = tx_data;
        end
    endtask

    initial begin
        #2000000;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n;
        // R1: reset state
        rst_k = 1'b1; step(); step();
        rst_k = 1'b0; step();
        chk(!tx_valid, "R1 tx_valid", tx_valid, 0);
        chk(!busy, "R1 busy", busy, 0);
        chk(in_ready, "R1 in_ready", in_ready, 1);

        // free-flowing fill up to the first marker
        p_in = 100; p_tx = 100;
        n = 0;
        while (phase != 2 && n < 200) begin step(); n++; end
        p_in = 100;
        step();
        chk(busy && !in_ready, "R4 closed", busy, 1);
        // R7: unrelated bytes while waiting
        rx_go = 1'b1; rx_val = 8'h15; step();
        rx_go = 1'b1; rx_val = 8'h86; step();
        step();
        chk(busy, "R7 noise ignored", busy, 1);
        // R6: acknowledge opens the gate
        rx_go = 1'b1; rx_val = 8'h06; step();
        step();
        chk(!busy, "R6 released", busy, 0);
        // R7: acknowledge while open changes nothing; R6: full block after reload
        n = (last_take) ? 1 : 0;
        rx_go = 1'b1; rx_val = 8'h06;
        while (phase == 0 && n < 100) begin step(); if (last_take) n++; end
        chk(n == BLK, "R6 block length after reload", n, BLK);
        chk(n == BLK, "R7 stray ack kept block length", n, BLK);

        // random traffic with acks and noise
        p_in = 70; p_tx = 50;
        for (int i = 0; i < 4000; i++) begin
            if (phase == 2 && ($urandom % 4) == 0) begin
                rx_go  = 1'b1;
                rx_val = (($urandom % 3) == 0) ? 8'h06 : 8'($urandom);
            end else if (phase == 0 && ($urandom % 20) == 0) begin
                rx_go = 1'b1; rx_val = 8'h06;
            end
            step();
        end

        // heavy backpressure
        p_in = 90; p_tx = 10;
        for (int i = 0; i < 1500; i++) begin
            if (phase == 2 && ($urandom % 5) == 0) begin rx_go = 1'b1; rx_val = 8'h06; end
            step();
        end

        // R8: reset in the middle of a block
        p_in = 100; p_tx = 100;
        n = 0;
        while (!(phase == 0 && cnt >= 5) && n < 400) begin
            if (phase == 2) begin rx_go = 1'b1; rx_val = 8'h06; end
            step(); n++;
        end
        rst_k = 1'b1; step();
        rst_k = 1'b0; step();
        chk(!busy && !tx_valid, "R8 cleared", {busy, tx_valid}, 0);
        n = (last_take) ? 1 : 0;
        while (phase == 0 && n < 100) begin step(); if (last_take) n++; end
        chk(n == BLK, "R8 full block after reset", n, BLK);

        p_in = 60; p_tx = 60;
        for (int i = 0; i < 2000; i++) begin
            if (phase == 2 && ($urandom % 3) == 0) begin rx_go = 1'b1; rx_val = 8'h06; end
            step();
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule